// File: doc/BRIEF.md
# Fully Associative Tag Store with Round-Robin Victim Pointer

This block holds the tags of a 64-entry fully associative cache and picks which entry to overwrite when a new block arrives. Any block can sit in any entry. A lookup tag is compared with every valid entry at the same time. The block reports a hit and the index of the matching entry in the same cycle. It holds no data storage and has no memory interface. A surrounding cache controller uses the hit index to address its data array and uses the victim index to place a refill.

Victim selection uses one replacement pointer as a cheap stand-in for least-recently-used. The pointer names one entry. It moves on by one, wrapping at the last entry, only when an access touches the entry it currently names. Accesses to any other entry leave it where it is, so a heavily used entry tends to push the pointer past itself.

Empty entries are always filled before the pointer is consulted. When an entry is invalid, the lowest-numbered invalid entry is offered as the victim. Installing a tag at the pointed entry counts as touching it, so the pointer then advances.

Top module: `faTagStore`

## Requirements
- R1: After reset every entry is invalid, the replacement pointer is 0 and the offered victim index is 0.
- R2: When `lookupValid` is high and a valid entry holds `lookupTag`, `hit` is 1 in the same cycle and `hitIdx` gives the lowest-numbered such entry.
- R3: An invalid entry never produces a hit, whatever tag it last held or what the lookup tag is; `hitIdx` reads 0 whenever `hit` is 0.
- R4: A cycle with `allocValid` high writes `allocTag` into the entry named by `victimIdx` in that cycle and marks it valid; from the next cycle a lookup of that tag hits at that index and the tag it replaced misses.
- R5: While at least one entry is invalid, `victimIdx` is the lowest-numbered invalid entry.
- R6: When all entries are valid, `victimIdx` equals the replacement pointer `replPtr`.
- R7: A qualified lookup that hits the entry named by `replPtr` makes `replPtr` one greater on the next cycle, and entry 63 wraps to 0.
- R8: A lookup that hits any other entry, a lookup that misses, and an idle cycle each leave `replPtr` unchanged.
- R9: An allocation into the entry named by `replPtr` advances the pointer by exactly one. This holds also when a hit on that same entry happens in the same cycle.
- R10: With `lookupValid` low, `hit` is 0 even if `lookupTag` matches a valid entry, and the pointer does not move because of the lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Qualifies the lookup tag |
| lookupTag | input | 27 | Tag to search for (address bits 31 to 5) |
| allocValid | input | 1 | Install `allocTag` at `victimIdx` this cycle |
| allocTag | input | 27 | Tag to install |
| hit | output | 1 | Lookup matched a valid entry (combinational) |
| hitIdx | output | 6 | Index of the matching entry, 0 on a miss |
| victimIdx | output | 6 | Entry the next allocation will fill |
| replPtr | output | 6 | Current replacement pointer |

## Verification
`hit`, `hitIdx` and `victimIdx` depend combinationally on the lookup inputs and on the stored state. Their expected values are therefore due in the same cycle in which the inputs are applied. Tag writes, valid bits and pointer moves take effect at the following rising edge and first show up in the next cycle's outputs. The driver applies inputs at a falling edge and queues the expected outputs for that cycle. The expected values come from a reference model that reflects every earlier edge. The monitor compares them 2 ns later, so each state change is first checked exactly one cycle after the stimulus that caused it.

// File: rtl/faTagPkg.sv
package faTagPkg;
  // Strobes from the replacement control to the tag datapath
  typedef struct packed {
    logic allocEn;   // write the victim entry this cycle
    logic touchPtr;  // the pointed entry is accessed this cycle
  } tagStrobes_t;
endpackage

// File: rtl/tagDatapath.sv
module tagDatapath
  import faTagPkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int TAG_W = 27,
  parameter int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TAG_W-1:0] lookupTag,
  input  logic [TAG_W-1:0] allocTag,
  input  tagStrobes_t      strobes,
  input  logic [IDX_W-1:0] victimIdx,
  output logic             matchAny,
  output logic [IDX_W-1:0] matchIdx,
  output logic             freeAny,
  output logic [IDX_W-1:0] freeIdx
);
  logic [NUM_ENTRIES-1:0] validQ;
  logic [NUM_ENTRIES-1:0] matchVec;
  logic [TAG_W-1:0]       tagQ [NUM_ENTRIES];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : gEntry
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(e);
    logic wrSel;
    assign wrSel = strobes.allocEn && (victimIdx == MY_IDX);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[e] <= 1'b0;
        tagQ[e]   <= '0;
      end else if (wrSel) begin
        validQ[e] <= 1'b1;
        tagQ[e]   <= allocTag;
      end
    end

    assign matchVec[e] = validQ[e] && (tagQ[e] == lookupTag);
  end

  // Lowest-index priority encoders for matches and free entries
  always_comb begin
    matchIdx = '0;
    freeIdx  = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) matchIdx = IDX_W'(i);
      if (!validQ[i])  freeIdx  = IDX_W'(i);
    end
  end

  assign matchAny = |matchVec;
  assign freeAny  = ~&validQ;

  // R4
  wr_sets_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.allocEn |=> validQ[$past(victimIdx)]);

  // R3
  match_only_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchAny |-> validQ[matchIdx]);

  // R5
  free_is_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    freeAny |-> !validQ[freeIdx]);
endmodule

// File: rtl/replCtrl.sv
module replCtrl
  import faTagPkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic             allocValid,
  input  logic             matchAny,
  input  logic [IDX_W-1:0] matchIdx,
  input  logic             freeAny,
  input  logic [IDX_W-1:0] freeIdx,
  output tagStrobes_t      strobes,
  output logic             hit,
  output logic [IDX_W-1:0] victimIdx,
  output logic [IDX_W-1:0] ptrQ
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic [IDX_W-1:0] ptrNext;

  assign hit       = lookupValid && matchAny;
  assign victimIdx = freeAny ? freeIdx : ptrQ;

  always_comb begin
    strobes.allocEn  = allocValid;
    strobes.touchPtr = (hit && (matchIdx == ptrQ)) ||
                       (allocValid && (victimIdx == ptrQ));
  end

  assign ptrNext = (ptrQ == LAST_IDX) ? '0 : ptrQ + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN)                 ptrQ <= '0;
    else if (strobes.touchPtr) ptrQ <= ptrNext;
  end

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit && matchIdx == ptrQ) |=>
      ptrQ == (($past(ptrQ) == LAST_IDX) ? '0 : $past(ptrQ) + 1'b1));

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!allocValid && !(hit && matchIdx == ptrQ)) |=> $stable(ptrQ));

  // R6
  full_uses_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !freeAny |-> victimIdx == ptrQ);
endmodule

// File: rtl/faTagStore.sv
module faTagStore
  import faTagPkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int TAG_W = 27,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [TAG_W-1:0] lookupTag,
  input  logic             allocValid,
  input  logic [TAG_W-1:0] allocTag,
  output logic             hit,
  output logic [IDX_W-1:0] hitIdx,
  output logic [IDX_W-1:0] victimIdx,
  output logic [IDX_W-1:0] replPtr
);
  tagStrobes_t      strobes;
  logic             matchAny;
  logic [IDX_W-1:0] matchIdx;
  logic             freeAny;
  logic [IDX_W-1:0] freeIdx;

  tagDatapath #(.NUM_ENTRIES(NUM_ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .lookupTag(lookupTag), .allocTag(allocTag),
    .strobes(strobes), .victimIdx(victimIdx), .matchAny(matchAny),
    .matchIdx(matchIdx), .freeAny(freeAny), .freeIdx(freeIdx));

  replCtrl #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .allocValid(allocValid),
    .matchAny(matchAny), .matchIdx(matchIdx), .freeAny(freeAny),
    .freeIdx(freeIdx), .strobes(strobes), .hit(hit), .victimIdx(victimIdx),
    .ptrQ(replPtr));

  assign hitIdx = hit ? matchIdx : '0;

  // R10
  no_unqualified_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !hit);

  // R3
  miss_idx_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> hitIdx == '0);
endmodule

// File: tb/tb_faTagStore.sv
module tb_faTagStore;
  localparam int N = 64;
  localparam int TW = 27;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0;
  logic [TW-1:0] lookupTag = '0;
  logic allocValid = 1'b0;
  logic [TW-1:0] allocTag = '0;
  logic hit;
  logic [5:0] hitIdx, victimIdx, replPtr;

  always #4 clk = ~clk;  // 125 MHz

  faTagStore dut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupTag(lookupTag),
    .allocValid(allocValid), .allocTag(allocTag), .hit(hit), .hitIdx(hitIdx),
    .victimIdx(victimIdx), .replPtr(replPtr));

  typedef struct {
    string      req;
    logic       expHit;
    logic [5:0] expIdx;
    logic [5:0] expVictim;
    logic [5:0] expPtr;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Reference model state
  bit          mValid [N];
  logic [TW-1:0] mTag [N];
  int          mPtr;

  task automatic compare(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: checks queued expectations 2 ns after each falling edge
  always begin
    @(negedge clk);
    #2;
    while (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      compare(it.req, "hit", int'(hit), int'(it.expHit));
      compare(it.req, "hitIdx", int'(hitIdx), int'(it.expIdx));
      compare(it.req, "victimIdx", int'(victimIdx), int'(it.expVictim));
      compare(it.req, "replPtr", int'(replPtr), int'(it.expPtr));
    end
  end

  // Driver: apply one cycle of stimulus, queue expectations, update the model
  task automatic step(input string req, input bit lv, input logic [TW-1:0] lt,
                      input bit av, input logic [TW-1:0] at);
    expItem_t it;
    int victim;
    int midx;
    bit mhit;
    bit touch;
    @(negedge clk);
    lookupValid = lv; lookupTag = lt; allocValid = av; allocTag = at;
    mhit = 1'b0; midx = 0; victim = -1;
    for (int i = 0; i < N; i++) begin
      if (!mhit && mValid[i] && mTag[i] == lt && lv) begin mhit = 1'b1; midx = i; end
      if (victim < 0 && !mValid[i]) victim = i;
    end
    if (victim < 0) victim = mPtr;
    it.req = req; it.expHit = mhit; it.expIdx = 6'(midx);
    it.expVictim = 6'(victim); it.expPtr = 6'(mPtr);
    expQ.push_back(it);
    touch = (mhit && midx == mPtr) || (av && victim == mPtr);
    if (av) begin mValid[victim] = 1'b1; mTag[victim] = at; end
    if (touch) mPtr = (mPtr + 1) % N;
  endtask

  function automatic logic [TW-1:0] tagOf(input int k);
    return TW'(32'h0000_0100 + k * 7);
  endfunction

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin mValid[i] = 1'b0; mTag[i] = '0; end
    mPtr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    step("R1", 1'b0, '0, 1'b0, '0);              // reset state
    step("R3", 1'b1, '0, 1'b0, '0);              // invalid entries never hit
    // Fill 10 entries: lowest invalid chosen, pointer follows the fill
    for (int k = 0; k < 10; k++) step("R5", 1'b0, '0, 1'b1, tagOf(k));
    step("R2", 1'b1, tagOf(3), 1'b0, '0);        // hit entry 3
    step("R8", 1'b1, tagOf(3), 1'b0, '0);        // pointer held after non-pointer hit
    step("R8", 1'b1, 27'h7ff_0000, 1'b0, '0);    // miss
    step("R3", 1'b1, tagOf(10), 1'b0, '0);       // not yet installed
    step("R10", 1'b0, tagOf(5), 1'b0, '0);       // unqualified lookup
    for (int k = 10; k < N; k++) step("R9", 1'b0, '0, 1'b1, tagOf(k));
    step("R6", 1'b0, '0, 1'b0, '0);              // full: victim = pointer 0
    step("R2", 1'b1, tagOf(63), 1'b0, '0);       // hit highest entry
    // Walk the pointer with hits on the pointed entry up to 63, then wrap
    for (int k = 0; k < N; k++) step("R7", 1'b1, tagOf(k), 1'b0, '0);
    step("R7", 1'b0, '0, 1'b0, '0);              // pointer wrapped to 0
    // Replace entry 0 at the pointer
    step("R4", 1'b0, '0, 1'b1, 27'h555_1234);
    step("R4", 1'b1, 27'h555_1234, 1'b0, '0);
    step("R4", 1'b1, tagOf(0), 1'b0, '0);        // old tag gone
    step("R10", 1'b0, tagOf(1), 1'b0, '0);       // pointer 1 not moved by idle lookup
    // Hit on pointed entry with allocation there in same cycle: one step
    step("R9", 1'b1, tagOf(1), 1'b1, 27'h2aa_0001);
    step("R9", 1'b1, 27'h2aa_0001, 1'b0, '0);
    step("R6", 1'b1, tagOf(40), 1'b0, '0);
    step("R1", 1'b0, '0, 1'b0, '0);
    @(negedge clk);
    #5;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule